// File: doc/BRIEF.md
# Serial Video Link Frame Builder

This block sits on the camera side of a single-lane serial video link. It samples a parallel pixel interface (a 14-bit pixel word, a line-valid level, a frame-valid level and six general-purpose input levels) on a chosen transition of the pixel clock. It packs each sample into a 28-bit serial frame that begins with a clock start bit and ends with a clock stop bit, so the receiver can recover timing from the data itself and needs no separate clock wire. A 4-bit CRC over the payload goes just before the stop bit.

The whole block runs in one fast system clock domain. The pixel clock arrives as an ordinary input level and is edge-detected inside the block. A bit-rate enable strobe advances the serial output one bit at a time, LSB first. One holding register decouples the pixel rate from the serial rate. A sample that arrives while the holding register is full and the shifter is busy is dropped, and a sticky overrun flag records it until it is cleared.

Top module: `vlink_framer`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first captured sample has been loaded, `ser_out` is 0 and `ovr` is 0.
- R2: A frame is 28 serial bits, where bit k is the value of `ser_out` at the k-th `bit_en` cycle after the frame loads. Bit 0 is the start bit (1). Bits 1..14 are pixel data bits 0..13. Bit 15 is the line-valid level and bit 16 is the frame-valid level. Bits 17..22 are GPIO bits 0..5. Bits 23..26 are CRC bits c[0]..c[3]. Bit 27 is the stop bit (0). Outside a frame `ser_out` is 0.
- R3: The CRC register c starts at 0. For each of the 22 payload bits (frame bits 1..22, in transmit order), fb = c[3] xor bit, and c becomes {c[2], c[1], c[0] xor fb, fb}. This is the polynomial x^4 + x + 1.
- R4: `ser_out` advances exactly one frame bit per cycle with `bit_en` high, and holds its value while `bit_en` is low.
- R5: With `cap_fall` = 0, the inputs are captured in the clock cycle in which `pix_clk` is first seen high after being low. With `cap_fall` = 1, they are captured on the high-to-low transition instead. The other transition captures nothing.
- R6: With the shifter idle and the holding register empty, the start bit appears on `ser_out` after the third rising `clk` edge that sees the selected `pix_clk` transition. That is a fixed latency of three clock edges.
- R7: One captured sample is held while a frame is shifting. Frames go out in capture order with no sample lost, as long as no overrun occurs.
- R8: A sample captured while the holding register is full and the shifter is still busy is discarded and never sent. `ovr` then rises and stays high until cleared.
- R9: `ovr_clr` high for one cycle clears `ovr`. If an overrun occurs in the same cycle, the overrun wins and `ovr` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Pixel clock level, sampled by `clk` |
| cap_fall | input | 1 | 0: capture on pixel clock rise, 1: on fall |
| pix_data | input | 14 | Pixel data word |
| line_vld | input | 1 | Line-valid (horizontal sync) level |
| frame_vld | input | 1 | Frame-valid (vertical sync) level |
| gpio_in | input | 6 | General-purpose input levels |
| bit_en | input | 1 | Serial bit-rate strobe |
| ovr_clr | input | 1 | Clears the overrun flag |
| ser_out | output | 1 | Serial bitstream, LSB first |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The overrun set and the overrun clear can land in the same clock cycle. The bench provokes this by holding `bit_en` low so that the shifter and the holding register both stay full. It then asserts `ovr_clr` in exactly the cycle in which the next captured sample is presented, and expects `ovr` to read 1 afterwards. A second coincidence is a new capture arriving in the cycle the holding register drains into the shifter. Streams whose pixel period sits close to the frame time provoke it. It is judged by a reference deserialiser, which must recover every driven sample in order, with a correct CRC and stop bit.

// File: rtl/vlink_pkg.sv
// Shared constants for the serial video link frame builder.
// Assumes CRC_POLY holds the low-order terms of a degree-CRC_W polynomial.
package vlink_pkg;
    localparam int CRC_W = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011; // x^4 + x + 1
    localparam logic START_BIT = 1'b1;
    localparam logic STOP_BIT  = 1'b0;
    localparam int SYNC_W = 2;                       // line-valid + frame-valid
endpackage

// File: rtl/vlink_capture.sv
// Pixel-side capture stage. Edge-detects the pixel clock level in the clk
// domain and registers the parallel sample on the selected transition.
// Assumes the parallel inputs are stable in the clk cycle where the chosen
// pix_clk transition is first visible.
module vlink_capture #(
    parameter int PAY_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_clk,
    input  logic             cap_fall,
    input  logic [PAY_W-1:0] samp_i,
    output logic             vld_o,
    output logic [PAY_W-1:0] samp_o
);
    logic pclk_q;
    logic edge_hit;

    // Select which pixel clock transition triggers a capture.
    always_comb begin
        if (cap_fall) edge_hit = pclk_q & ~pix_clk;
        else          edge_hit = ~pclk_q & pix_clk;
    end

    // Track the previous pixel clock level and register the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q <= 1'b0;
            vld_o  <= 1'b0;
            samp_o <= '0;
        end else begin
            pclk_q <= pix_clk;
            vld_o  <= edge_hit;
            if (edge_hit) samp_o <= samp_i;
        end
    end
endmodule

// File: rtl/vlink_hold.sv
// Single-entry holding register between capture and shifter, with a sticky
// overrun flag. A capture is accepted when the register is empty or is being
// drained by the shifter in the same cycle; otherwise it is dropped.
// Assumes take_i is only raised while full_o is high.
module vlink_hold #(
    parameter int PAY_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [PAY_W-1:0] samp_i,
    input  logic             take_i,
    input  logic             ovr_clr_i,
    output logic             full_o,
    output logic [PAY_W-1:0] samp_o,
    output logic             ovr_o
);
    logic accept;
    logic drop;

    // Decide whether the incoming sample is stored or lost.
    always_comb begin
        accept = vld_i & (~full_o | take_i);
        drop   = vld_i & full_o & ~take_i;
    end

    // Holding register occupancy and contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            samp_o <= '0;
        end else begin
            if (accept) begin
                full_o <= 1'b1;
                samp_o <= samp_i;
            end else if (take_i) begin
                full_o <= 1'b0;
            end
        end
    end

    // Sticky overrun flag; a new drop takes precedence over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_o <= 1'b0;
        else if (drop)      ovr_o <= 1'b1;
        else if (ovr_clr_i) ovr_o <= 1'b0;
    end
endmodule

// File: rtl/vlink_crc.sv
// Combinational CRC over the payload in transmit order (bit 0 first),
// MSB-feedback form, initial value zero. Depth grows linearly with PAY_W.
module vlink_crc
    import vlink_pkg::*;
#(
    parameter int PAY_W = 22
) (
    input  logic [PAY_W-1:0] pay_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // Walk the payload one bit at a time through the CRC register.
    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = 0; i < PAY_W; i++) begin
            fb  = acc[CRC_W-1] ^ pay_i[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/vlink_shifter.sv
// Frame shifter. Loads a full frame whenever it is idle and a sample waits,
// then shifts one bit right per bit_en, zero-filling, until FRAME_W bits
// are out. The output is always bit 0 of the shift register.
module vlink_shifter #(
    parameter int FRAME_W = 28,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               ready_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               take_o,
    output logic               active_o,
    output logic               ser_o
);
    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   cnt;
    logic               last_bit;

    // Load request and end-of-frame detection.
    always_comb begin
        take_o   = ~active_o & ready_i;
        last_bit = (cnt == CNT_W'(FRAME_W - 1));
        ser_o    = sreg[0];
    end

    // Frame load, bit advance and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            cnt      <= '0;
            active_o <= 1'b0;
        end else if (take_o) begin
            sreg     <= frame_i;
            cnt      <= '0;
            active_o <= 1'b1;
        end else if (active_o && bit_en) begin
            sreg <= {1'b0, sreg[FRAME_W-1:1]};
            if (last_bit) begin
                cnt      <= '0;
                active_o <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vlink_framer.sv
// Serial video link frame builder top. Captures a parallel pixel sample on
// the selected pixel clock edge, buffers it, appends start bit, CRC and stop
// bit, and shifts the frame out LSB first under a bit-rate enable.
// Assumes pix_clk is slow enough to be sampled cleanly by clk.
module vlink_framer
    import vlink_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int GPIO_W = 6,
    localparam int PAY_W   = DATA_W + SYNC_W + GPIO_W,
    localparam int FRAME_W = 1 + PAY_W + CRC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              cap_fall,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              line_vld,
    input  logic              frame_vld,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              bit_en,
    input  logic              ovr_clr,
    output logic              ser_out,
    output logic              ovr
);
    logic [PAY_W-1:0]   in_samp;
    logic               cap_vld;
    logic [PAY_W-1:0]   cap_samp;
    logic               hold_full;
    logic [PAY_W-1:0]   hold_samp;
    logic               take;
    logic               shift_active;
    logic [CRC_W-1:0]   crc;
    logic [FRAME_W-1:0] frame;

    // Payload in transmit order: data, line-valid, frame-valid, GPIO.
    always_comb in_samp = {gpio_in, frame_vld, line_vld, pix_data};

    // Frame: start bit first, then payload, CRC, stop bit last.
    always_comb frame = {STOP_BIT, crc, hold_samp, START_BIT};

    vlink_capture #(.PAY_W(PAY_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_clk  (pix_clk),
        .cap_fall (cap_fall),
        .samp_i   (in_samp),
        .vld_o    (cap_vld),
        .samp_o   (cap_samp)
    );

    vlink_hold #(.PAY_W(PAY_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (cap_vld),
        .samp_i    (cap_samp),
        .take_i    (take),
        .ovr_clr_i (ovr_clr),
        .full_o    (hold_full),
        .samp_o    (hold_samp),
        .ovr_o     (ovr)
    );

    vlink_crc #(.PAY_W(PAY_W)) u_crc (
        .pay_i (hold_samp),
        .crc_o (crc)
    );

    vlink_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .ready_i  (hold_full),
        .frame_i  (frame),
        .take_o   (take),
        .active_o (shift_active),
        .ser_o    (ser_out)
    );
endmodule

// File: rtl/vlink_framer_chk.sv
// Protocol checker for vlink_framer, attached by bind. Observes ports and
// the capture/hold/shift handover signals; drives nothing into the design.
module vlink_framer_chk #(
    parameter int FRAME_W = 28,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic ovr_clr,
    input logic ser_out,
    input logic ovr,
    input logic active,
    input logic hold_full,
    input logic cap_vld
);
    logic [CNT_W-1:0] nbits;

    // Count bit strobes seen inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) nbits <= '0;
        else if (bit_en)       nbits <= nbits + 1'b1;
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !ser_out); // R1
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ser_out); // R2
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_en && nbits == CNT_W'(FRAME_W - 1)) |=> !active); // R2
    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> nbits < CNT_W'(FRAME_W)); // R2
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_en) |=> $stable(ser_out)); // R4
    AST_DRAIN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_full) |-> $rose(active)); // R7
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(cap_vld && hold_full)); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr); // R8
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && ovr_clr && !cap_vld) |=> !ovr); // R9
endmodule

bind vlink_framer vlink_framer_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .ovr_clr   (ovr_clr),
    .ser_out   (ser_out),
    .ovr       (ovr),
    .active    (shift_active),
    .hold_full (hold_full),
    .cap_vld   (cap_vld)
);

// File: tb/vlink_framer_test.sv
// Bench for vlink_framer: directed corners plus seeded random streams,
// checked by a reference deserialiser built from the requirements.
module vlink_framer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAY_W   = 22;
    localparam int FRAME_W = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic        cap_fall = 1'b0;
    logic [13:0] pix_data = '0;
    logic        line_vld = 1'b0;
    logic        frame_vld = 1'b0;
    logic [5:0]  gpio_in = '0;
    logic        bit_en = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        ser_out;
    logic        ovr;

    int n_chk = 0;
    int n_fail = 0;
    int ben_mode = 1;       // 0 off, 1 every cycle, 2 random
    bit done = 1'b0;
    logic [PAY_W-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlink_framer uut (
        .clk (clk), .rst_n (rst_n), .pix_clk (pix_clk), .cap_fall (cap_fall),
        .pix_data (pix_data), .line_vld (line_vld), .frame_vld (frame_vld),
        .gpio_in (gpio_in), .bit_en (bit_en), .ovr_clr (ovr_clr),
        .ser_out (ser_out), .ovr (ovr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference CRC written in the register-update form stated in R3.
    function automatic logic [3:0] crc_ref(input logic [PAY_W-1:0] p);
        logic [3:0] c = 4'd0;
        for (int i = 0; i < PAY_W; i++) begin
            logic f = c[3] ^ p[i];
            c = {c[2], c[1], c[0] ^ f, f};
        end
        return c;
    endfunction

    // Reference deserialiser: picks bits at bit_en cycles, finds start/stop.
    logic [FRAME_W-1:0] rx_buf;
    int  rx_n = 0;
    bit  rx_in = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bit_en = 1'b0;
            rx_in  = 1'b0;
            rx_n   = 0;
        end else begin
            bit_en = (ben_mode == 1) || (ben_mode == 2 && $urandom_range(1) == 1);
            if (bit_en) begin
                if (!rx_in) begin
                    if (ser_out === 1'b1) begin
                        rx_in = 1'b1;
                        rx_buf[0] = 1'b1;
                        rx_n = 1;
                    end
                end else begin
                    rx_buf[rx_n] = ser_out;
                    rx_n++;
                    if (rx_n == FRAME_W) begin
                        logic [PAY_W-1:0] pay;
                        rx_in = 1'b0;
                        pay = rx_buf[PAY_W:1];
                        chk("R2 stop bit", 32'(rx_buf[FRAME_W-1]), 32'd0);
                        chk("R3 crc", 32'(rx_buf[FRAME_W-2:PAY_W+1]), 32'(crc_ref(pay)));
                        if (exp_q.size() == 0)
                            chk("R8 unexpected frame", 32'(pay), 32'hFFFF_FFFF);
                        else
                            chk("R2 R5 R7 payload", 32'(pay), 32'(exp_q.pop_front()));
                    end
                end
            end
        end
    end

    function automatic logic [PAY_W-1:0] pack(input logic [13:0] d, input logic h,
                                              input logic v, input logic [5:0] g);
        return {g, v, h, d};
    endfunction

    task automatic drive(input logic [PAY_W-1:0] s);
        {gpio_in, frame_vld, line_vld, pix_data} = s;
    endtask

    // One pixel period; the true sample is present only at the capture edge.
    task automatic send(input logic [PAY_W-1:0] s, input int half, input bit push);
        if (push) exp_q.push_back(s);
        if (!cap_fall) begin
            drive(s); pix_clk = 1'b1;
            repeat (half) @(negedge clk);
            drive(~s); pix_clk = 1'b0;
            repeat (half) @(negedge clk);
        end else begin
            drive(~s); pix_clk = 1'b1;
            repeat (half) @(negedge clk);
            drive(s); pix_clk = 1'b0;
            repeat (half) @(negedge clk);
        end
    endtask

    task automatic drain();
        int g = 0;
        while (exp_q.size() != 0 && g < 20000) begin
            @(negedge clk);
            g++;
        end
        repeat (40) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        chk("R1 reset ser_out", 32'(ser_out), 32'd0);
        chk("R1 reset ovr", 32'(ovr), 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 idle before first sample", 32'(ser_out), 32'd0);
        chk("R1 ovr after reset", 32'(ovr), 32'd0);

        // R6: fixed latency from capture edge to start bit.
        begin
            logic [PAY_W-1:0] s = pack(14'h2A5, 1'b1, 1'b0, 6'h15);
            exp_q.push_back(s);
            drive(s); pix_clk = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk("R6 no start after two edges", 32'(ser_out), 32'd0);
            @(negedge clk);
            chk("R6 start after three edges", 32'(ser_out), 32'd1);
            repeat (13) @(negedge clk);
            drive(~s); pix_clk = 1'b0;
            repeat (16) @(negedge clk);
        end

        // Corner payloads, rising edge (R2 R3 R5).
        send('0, 16, 1'b1);
        send('1, 16, 1'b1);
        send(pack(14'h0001, 1'b0, 1'b1, 6'h20), 16, 1'b1);
        // Random stream, rising edge, full rate.
        for (int i = 0; i < 60; i++) send(PAY_W'($urandom), 16, 1'b1);
        drain();

        // Random stream, falling edge, throttled bit rate (R4 R5).
        cap_fall = 1'b1;
        ben_mode = 2;
        for (int i = 0; i < 60; i++) send(PAY_W'($urandom), 40, 1'b1);
        drain();
        chk("R7 all samples delivered", 32'(exp_q.size()), 32'd0);

        // Overrun and same-cycle set/clear (R4 R8 R9).
        cap_fall = 1'b0;
        ben_mode = 0;
        repeat (4) @(negedge clk);
        send(pack(14'h1111, 1'b1, 1'b1, 6'h01), 6, 1'b1);
        send(pack(14'h2222, 1'b0, 1'b1, 6'h02), 6, 1'b1);
        chk("R8 no overrun while one entry free", 32'(ovr), 32'd0);
        chk("R4 start bit held without bit_en", 32'(ser_out), 32'd1);
        send(pack(14'h3333, 1'b1, 1'b0, 6'h03), 6, 1'b0);
        chk("R8 overrun set", 32'(ovr), 32'd1);
        repeat (10) @(negedge clk);
        chk("R8 overrun sticky", 32'(ovr), 32'd1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R9 overrun cleared", 32'(ovr), 32'd0);
        drive(pack(14'h0444, 1'b0, 1'b0, 6'h04)); pix_clk = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R9 set wins over clear", 32'(ovr), 32'd1);
        repeat (5) @(negedge clk);
        pix_clk = 1'b0;
        repeat (5) @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R9 cleared again", 32'(ovr), 32'd0);
        ben_mode = 1;
        drain();
        chk("R8 dropped samples never sent", 32'(exp_q.size()), 32'd0);
        chk("R1 line idle after drain", 32'(ser_out), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule